// File: doc/BRIEF.md
# Page-Buffered Byte Array Controller

This block sits behind a two-wire serial slave and owns the storage side of a byte-wide non-volatile array. It keeps the internal word address counter, gathers incoming write bytes into a one-page staging buffer, and replays them into the array during a timed internal write cycle that begins when the slave reports a stop. While that cycle runs, `busy` is high and every request from the slave is dropped. This lets the slave answer "not ready" while the write completes.

The array is split into pages of 128 bytes. Write bytes advance only the in-page part of the address, so a long burst wraps onto the start of its own page. Read bytes advance the whole address and wrap from the last byte of memory to byte zero. A write-protect input blocks the commit without disturbing the byte traffic. The address width is a parameter. It is 16 bits (512 pages) in the full-size part and smaller by default so the model stays light. The write cycle length is counted in system clocks.

Top module: `pgwr_ctrl`

## Requirements
- R1: After synchronous reset `busy` is 0, `rd_data` is 0, and the address counter is 0.
- R2: A cycle with `addr_load` high sets the counter to `addr_val`. A cycle with `rd_stb` high puts the byte at the counter on `rd_data` one clock later, and `rd_data` holds between reads.
- R3: Each accepted read adds one to the counter across the full address width, wrapping from the highest address to 0.
- R4: Each accepted write byte is staged at the in-page offset (low 7 bits) of the counter, and only those 7 bits increment. A burst longer than 128 bytes wraps to the start of the same page, and the later byte replaces the earlier one.
- R5: A commit writes only the offsets that received a byte since the last address load or stop. All other bytes of the page keep their old contents.
- R6: An accepted `stop` with at least one staged byte and `wp` low raises `busy` on the next clock and holds it for exactly WR_CYCLES clocks.
- R7: While `busy` is high, `addr_load`, `byte_stb`, `rd_stb` and `stop` are ignored. The counter, the staged bytes and `rd_data` do not change.
- R8: An accepted `stop` with no staged byte starts no write cycle, and `busy` stays 0.
- R9: If `wp` is high when `stop` is accepted, the staged bytes are discarded, the array is unchanged, and `busy` stays 0.
- R10: Between operations the counter holds the last accessed address plus one (in-page for writes). A read without a prior address load starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load the word address counter (highest priority) |
| addr_val | input | ADDR_W | Address value for a load |
| byte_stb | input | 1 | One received write byte (priority below load) |
| byte_data | input | DATA_W | Received write byte |
| rd_stb | input | 1 | Fetch one byte at the counter (priority below write) |
| stop | input | 1 | Stop condition seen on the bus (lowest priority) |
| wp | input | 1 | Write protect, sampled when stop is accepted |
| rd_data | output | DATA_W | Registered read byte |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bound checker watches every cycle for four things: the exact busy length and its cause, the dropping of all requests while busy, the in-page step for write bytes, and the full-width step for reads. It also checks that a stop with nothing staged, or a stop under write protect, leaves `busy` low. The following can only be shown by the bench scenarios, because each one depends on the contents of the array after a commit: which offsets a commit actually writes, page wrap with overwrite on bursts over 128 bytes, the memory-end wrap on reads, and the continuation of a current-address read. The bench reference model tracks the array, counter and staged bytes behaviourally, and compares `busy` and `rd_data` on every clock.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic {
    WC_IDLE = 1'b0,
    WC_RUN  = 1'b1
  } wcyc_state_t;
endpackage

// File: rtl/pgwr_addr_ctr.sv
module pgwr_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              wr_step,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] addr
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]  row;
  logic [PAGE_W-1:0] col;

  assign row = addr[ADDR_W-1:PAGE_W];
  assign col = addr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (wr_step) begin
      addr <= {row, col + PAGE_W'(1)};
    end else if (rd_step) begin
      addr <= addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     store_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_idx] <= wr_data;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        vld_q[i] <= 1'b0;
      end else if (wr_en && (wr_idx == PAGE_W'(i))) begin
        vld_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data = store_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign any_vld = |vld_q;
endmodule

// File: rtl/pgwr_wcycle.sv
module pgwr_wcycle
  import pgwr_pkg::*;
#(
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              cmt_en,
  output logic [PAGE_W-1:0] cmt_idx,
  output logic              last
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  wcyc_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WC_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        WC_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= WC_RUN;
        end
        default: begin
          if (cnt_q == CNT_W'(WR_CYCLES - 1)) begin
            state_q <= WC_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign busy    = (state_q == WC_RUN);
  assign cmt_en  = busy && (cnt_q < CNT_W'(PAGE_BYTES));
  assign cmt_idx = cnt_q[PAGE_W-1:0];
  assign last    = busy && (cnt_q == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 7,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              rd_stb,
  input  logic              stop,
  input  logic              wp,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              idle;
  logic              ld_acc, wr_acc, rd_acc, stop_acc, start;
  logic [ADDR_W-1:0] addr_q;
  logic [ROW_W-1:0]  page_q;
  logic              buf_clr, any_vld, buf_vld;
  logic [DATA_W-1:0] buf_byte;
  logic              cmt_en, last;
  logic [PAGE_W-1:0] cmt_idx;

  assign idle     = !busy;
  assign ld_acc   = idle && addr_load;
  assign wr_acc   = idle && !addr_load && byte_stb;
  assign rd_acc   = idle && !addr_load && !byte_stb && rd_stb;
  assign stop_acc = idle && !addr_load && !byte_stb && !rd_stb && stop;
  assign start    = stop_acc && any_vld && !wp;
  assign buf_clr  = ld_acc || (stop_acc && !start) || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (start) begin
      page_q <= addr_q[ADDR_W-1:PAGE_W];
    end
  end

  pgwr_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_acc),
    .load_val (addr_val),
    .wr_step  (wr_acc),
    .rd_step  (rd_acc),
    .addr     (addr_q)
  );

  pgwr_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_acc),
    .wr_idx  (addr_q[PAGE_W-1:0]),
    .wr_data (byte_data),
    .clr     (buf_clr),
    .rd_idx  (cmt_idx),
    .rd_data (buf_byte),
    .rd_vld  (buf_vld),
    .any_vld (any_vld)
  );

  pgwr_wcycle #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_wc (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .cmt_en  (cmt_en),
    .cmt_idx (cmt_idx),
    .last    (last)
  );

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (cmt_en && buf_vld),
    .waddr ({page_q, cmt_idx}),
    .wdata (buf_byte),
    .re    (rd_acc),
    .raddr (addr_q),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 7,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              stop,
  input logic              wp,
  input logic              any_vld,
  input logic              wr_acc,
  input logic              rd_acc,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] rd_data
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else run_q <= 0;
  end

  assert_busy_max_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_q < WR_CYCLES);

  assert_busy_full_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == WR_CYCLES);

  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(stop) && !$past(wp) && $past(any_vld)));

  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));

  assert_hold_rdata_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));

  assert_page_step_R4: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]))
               && (addr_q[PAGE_W-1:0] == $past(addr_q[PAGE_W-1:0]) + PAGE_W'(1)));

  assert_read_step_R3: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> addr_q == $past(addr_q) + ADDR_W'(1));

  assert_empty_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (stop && !busy && !any_vld) |=> !busy);

  assert_protect_R9: assert property (@(posedge clk) disable iff (rst)
    (stop && !busy && wp) |=> !busy);
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .stop    (stop),
  .wp      (wp),
  .any_vld (any_vld),
  .wr_acc  (wr_acc),
  .rd_acc  (rd_acc),
  .addr_q  (addr_q),
  .rd_data (rd_data)
);

// File: tb/sim_pgwr_ctrl.sv
`timescale 1ns/1ps
module sim_pgwr_ctrl;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int WRC = 150;
  localparam int DEPTH = 1 << AW;
  localparam int PB = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_load = 1'b0, byte_stb = 1'b0, rd_stb = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [AW-1:0] addr_val = '0;
  logic [DW-1:0] byte_data = '0;
  logic [DW-1:0] rd_data;
  logic busy;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pgwr_ctrl #(.ADDR_W(AW), .PAGE_W(7), .DATA_W(DW), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_val(addr_val),
    .byte_stb(byte_stb), .byte_data(byte_data), .rd_stb(rd_stb),
    .stop(stop), .wp(wp), .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference model
  int m_mem [DEPTH];
  int m_bd [PB];
  bit m_bv [PB];
  int m_addr, m_busy, m_rd;

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_busy = 0; m_rd = 0;
      for (int i = 0; i < PB; i++) m_bv[i] = 0;
    end else if (m_busy > 0) begin
      m_busy = m_busy - 1;
    end else if (addr_load) begin
      m_addr = int'(addr_val);
      for (int i = 0; i < PB; i++) m_bv[i] = 0;
    end else if (byte_stb) begin
      m_bd[m_addr % PB] = int'(byte_data);
      m_bv[m_addr % PB] = 1;
      m_addr = (m_addr / PB) * PB + ((m_addr + 1) % PB);
    end else if (rd_stb) begin
      m_rd = m_mem[m_addr];
      m_addr = (m_addr + 1) % DEPTH;
    end else if (stop) begin
      bit any;
      any = 0;
      for (int i = 0; i < PB; i++) if (m_bv[i]) any = 1;
      if (any && !wp) begin
        for (int i = 0; i < PB; i++)
          if (m_bv[i]) m_mem[(m_addr / PB) * PB + i] = m_bd[i];
        m_busy = WRC;
      end
      for (int i = 0; i < PB; i++) m_bv[i] = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == (m_busy > 0), {cur_req, " busy"}, int'(busy), int'(m_busy > 0));
      chk(int'(rd_data) == m_rd, {cur_req, " rd_data"}, int'(rd_data), m_rd);
    end
  end

  task automatic drive(input bit al, input int av, input bit bs, input int bd,
                       input bit rs, input bit st);
    @(negedge clk);
    addr_load = al; addr_val = AW'(av);
    byte_stb = bs; byte_data = DW'(bd);
    rd_stb = rs; stop = st;
  endtask

  task automatic nop(); drive(0, 0, 0, 0, 0, 0); endtask
  task automatic ld(input int a); drive(1, a, 0, 0, 0, 0); endtask
  task automatic wb(input int d); drive(0, 0, 1, d, 0, 0); endtask
  task automatic sp(); drive(0, 0, 0, 0, 0, 1); endtask

  task automatic rd(output int v);
    drive(0, 0, 0, 0, 1, 0);
    nop();
    v = int'(rd_data);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    forever begin
      nop();
      if (busy) n++;
      else break;
    end
  endtask

  task automatic rd_at(input int a, input string req, input int exp);
    int v;
    ld(a);
    rd(v);
    chk(v == exp, req, v, exp);
  endtask

  initial begin
    int n, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, counter at 0
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
    rd(v);
    chk(v == 0, "R1 counter", v, 0);

    // R6 / R2: single byte
    cur_req = "R6";
    ld(12'h105); wb(8'hA5); sp();
    wait_idle(n);
    chk(n == WRC, "R6 busy length", n, WRC);
    cur_req = "R2";
    rd_at(12'h105, "R2 read back", 8'hA5);
    nop(); nop();
    chk(rd_data == 8'hA5, "R2 rd_data holds", int'(rd_data), 8'hA5);

    // R4 / R10: 130-byte burst from offset 0x7E of page at 0x080
    cur_req = "R4";
    ld(12'h0FE);
    for (int k = 0; k < 130; k++) wb(k + 1);
    sp();
    wait_idle(n);
    cur_req = "R10";
    rd(v);
    chk(v == 3, "R10 current-address read after page wrap", v, 3);
    cur_req = "R4";
    rd_at(12'h0FE, "R4 overwrite offset 7E", 129);
    rd(v);
    chk(v == 130, "R4 overwrite offset 7F", v, 130);
    rd_at(12'h0C0, "R4 mid page", 8'h43);

    // R3: read wraps from top of memory to 0
    cur_req = "R3";
    ld(DEPTH - 1); wb(8'h77); sp(); wait_idle(n);
    ld(0); wb(8'h11); sp(); wait_idle(n);
    rd_at(DEPTH - 1, "R3 last byte", 8'h77);
    rd(v);
    chk(v == 8'h11, "R3 wrap to zero", v, 8'h11);

    // R5: partial write keeps neighbours
    cur_req = "R5";
    ld(12'h200);
    for (int k = 0; k < PB; k++) wb(8'hEE);
    sp(); wait_idle(n);
    ld(12'h210); wb(8'h01); wb(8'h02); sp(); wait_idle(n);
    rd_at(12'h20F, "R5 below", 8'hEE);
    rd(v); chk(v == 8'h01, "R5 first", v, 1);
    rd(v); chk(v == 8'h02, "R5 second", v, 2);
    rd(v); chk(v == 8'hEE, "R5 above", v, 8'hEE);

    // R8: stop with nothing staged
    cur_req = "R8";
    ld(12'h300); sp();
    wait_idle(n);
    chk(n == 0, "R8 no write cycle", n, 0);

    // R9: write protect
    cur_req = "R9";
    wp = 1'b1;
    ld(12'h300); wb(8'h99); sp();
    wait_idle(n);
    chk(n == 0, "R9 no write cycle", n, 0);
    wp = 1'b0;
    rd_at(12'h300, "R9 array unchanged", 0);

    // R7: requests ignored while busy
    cur_req = "R7";
    ld(12'h400); wb(8'h44); wb(8'h46); sp();
    ld(12'h400); wb(8'hFF); drive(0, 0, 0, 0, 1, 0); sp();
    chk(busy == 1'b1, "R7 still busy", int'(busy), 1);
    wait_idle(n);
    rd(v);
    chk(v == 0, "R7 counter kept", v, 0);
    rd_at(12'h401, "R7 stray byte dropped", 8'h46);
    rd_at(12'h400, "R7 first byte", 8'h44);

    nop(); nop();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule